// File: doc/BRIEF.md
# PCI Configuration Access Translator

This block sits between a host I/O port interface and a PCI bus master. It keeps a 32-bit configuration address register at one I/O port and exposes a 32-bit data window at a second port. When the enable bit of the address register is set, each host access to the data window becomes one configuration request. The request carries the bus address-phase value, a Type 0 / Type 1 flag, the direction and the host byte enables.

The address register names a bus, a device, a function and a register. A Type 0 access addresses the local segment. It places a single device-select bit in the upper address lines. Device 0 on bus 0 is the block's own device: its accesses go to a local register port and never reach PCI. A Type 1 access forwards the bus, device, function and register fields unchanged for bridges further down the hierarchy.

Any other host access goes out on an ordinary I/O request port. This covers the data window while disabled, a partial-width access to the address port, and any other port. Each of the three downstream targets is a simple request/done handshake. Only one access is in flight at a time.

Top module: `cfg_xlate`

## Requirements
- R1: After reset the address register reads 00000000h, no downstream request is raised and `host_ack` is low.
- R2: A host write to dword port 33Eh (byte port 0CF8h) with `host_be` = 1111 loads the address register and is acknowledged one cycle after acceptance without any downstream request. A full read of that port returns bit 31 as written, bits [23:2] as written and bits [30:24] and [1:0] as 0.
- R3: A write to port 33Eh with any `host_be` other than 1111 leaves the address register unchanged and is forwarded as an ordinary I/O request.
- R4: An access to port 33Fh (byte port 0CFCh) while address bit 31 is 0, or an access to any port other than 33Eh/33Fh, raises `io_req` with `io_port` equal to `host_port`.
- R5: With address bit 31 = 1, bus = 0 and device N in 1..20, a data-window access raises `pci_req` with `pci_type1` = 0. `pci_addr` bit 11+N is 1, bits [31:11] are otherwise 0, bits [10:2] are the function and register fields, and bits [1:0] are 00.
- R6: With bus = 0 and device above 20, `pci_addr[31:11]` is all 0. If the response flags `pci_mabort`, a read returns FFFFFFFFh and a write completes normally.
- R7: With bus = 0 and device = 0, `loc_req` is raised with `loc_index` = address bits [10:2], and no PCI request is made.
- R8: With bus nonzero, `pci_type1` = 1 and `pci_addr` = {8'h00, address bits [23:2], 2'b01}.
- R9: `dn_wr`, `dn_be` and `dn_wdata` equal the host's direction, byte enables and write data for the forwarded access.
- R10: At most one of `pci_req`, `loc_req`, `io_req` is high. It stays high with stable fields until its `done` input. `host_ack` is high for exactly the one cycle after that `done` and carries the response data on reads and 0 on writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_req | input | 1 | Host access request, held until `host_ack` |
| host_wr | input | 1 | 1 = write, 0 = read |
| host_port | input | 14 | I/O dword port address (byte address bits [15:2]) |
| host_be | input | 4 | Host byte enables, active high |
| host_wdata | input | 32 | Host write data |
| host_ack | output | 1 | One-cycle completion strobe |
| host_rdata | output | 32 | Read data, valid with `host_ack` |
| dn_wr | output | 1 | Direction of the forwarded access |
| dn_be | output | 4 | Byte enables of the forwarded access |
| dn_wdata | output | 32 | Write data of the forwarded access |
| pci_req | output | 1 | Configuration request to the PCI master |
| pci_type1 | output | 1 | 1 = Type 1, 0 = Type 0 |
| pci_addr | output | 32 | Address-phase value |
| pci_done | input | 1 | PCI cycle finished |
| pci_mabort | input | 1 | PCI cycle ended in master abort |
| pci_rdata | input | 32 | PCI read data |
| loc_req | output | 1 | Request to the local configuration registers |
| loc_index | output | 9 | Function and register number for the local access |
| loc_done | input | 1 | Local access finished |
| loc_rdata | input | 32 | Local read data |
| io_req | output | 1 | Ordinary I/O request |
| io_port | output | 14 | I/O dword port of the forwarded access |
| io_done | input | 1 | I/O access finished |
| io_rdata | input | 32 | I/O read data |

## Verification
A request accepted at a clock edge shows its downstream request and fields after that same edge. A `done` seen at a later edge turns into `host_ack` and read data after that edge. An address-register access acknowledges after the accepting edge. The bench plays the host and all three targets at falling edges and moves its expected request and acknowledge flags at the same falling edges. A monitor compares those flags a quarter period after every rising edge. The address fields are checked one cycle after acceptance, and read data is checked in the acknowledge cycle, against values the bench computes from its own copy of the address register.

// File: rtl/cfg_xlate.sv
module cfg_xlate #(
  parameter logic [13:0] ADDR_PORT = 14'h33E,
  parameter logic [13:0] DATA_PORT = 14'h33F,
  parameter int          MAX_DEV   = 20
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        host_req,
  input  logic        host_wr,
  input  logic [13:0] host_port,
  input  logic [3:0]  host_be,
  input  logic [31:0] host_wdata,
  output logic        host_ack,
  output logic [31:0] host_rdata,
  output logic        dn_wr,
  output logic [3:0]  dn_be,
  output logic [31:0] dn_wdata,
  output logic        pci_req,
  output logic        pci_type1,
  output logic [31:0] pci_addr,
  input  logic        pci_done,
  input  logic        pci_mabort,
  input  logic [31:0] pci_rdata,
  output logic        loc_req,
  output logic [8:0]  loc_index,
  input  logic        loc_done,
  input  logic [31:0] loc_rdata,
  output logic        io_req,
  output logic [13:0] io_port,
  input  logic        io_done,
  input  logic [31:0] io_rdata
);

  typedef enum logic [2:0] {S_IDLE, S_PCI, S_LOC, S_IO, S_ACK} state_t;
  state_t state;

  logic        cfg_en;
  logic [23:2] cfg_field;
  logic [31:0] rdata_q;

  wire  [7:0]  bus_no   = cfg_field[23:16];
  wire  [4:0]  dev_no   = cfg_field[15:11];
  wire         go_t1    = bus_no != 8'h00;
  wire         go_local = !go_t1 && dev_no == 5'd0;
  wire         hit_addr = host_port == ADDR_PORT && host_be == 4'hF;
  wire         hit_data = host_port == DATA_PORT && cfg_en;
  wire  [31:0] readback = {cfg_en, 7'b0, cfg_field, 2'b00};

  logic [MAX_DEV-1:0] idsel;
  for (genvar i = 0; i < MAX_DEV; i++) begin : g_idsel
    assign idsel[i] = dev_no == 5'(i + 1);
  end

  wire [31:0] ad_t0 = {idsel, 1'b0, cfg_field[10:2], 2'b00};
  wire [31:0] ad_t1 = {8'h00, cfg_field, 2'b01};

  assign pci_req  = state == S_PCI;
  assign loc_req  = state == S_LOC;
  assign io_req   = state == S_IO;
  assign host_ack = state == S_ACK;
  assign host_rdata = rdata_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state     <= S_IDLE;
      cfg_en    <= 1'b0;
      cfg_field <= '0;
      rdata_q   <= '0;
      dn_wr     <= 1'b0;
      dn_be     <= '0;
      dn_wdata  <= '0;
      pci_type1 <= 1'b0;
      pci_addr  <= '0;
      loc_index <= '0;
      io_port   <= '0;
    end else begin
      case (state)
        S_IDLE: if (host_req) begin
          dn_wr    <= host_wr;
          dn_be    <= host_be;
          dn_wdata <= host_wdata;
          if (hit_addr) begin
            if (host_wr) begin
              cfg_en    <= host_wdata[31];
              cfg_field <= host_wdata[23:2];
            end
            rdata_q <= host_wr ? 32'h0 : readback;
            state   <= S_ACK;
          end else if (hit_data) begin
            if (go_local) begin
              loc_index <= cfg_field[10:2];
              state     <= S_LOC;
            end else begin
              pci_addr  <= go_t1 ? ad_t1 : ad_t0;
              pci_type1 <= go_t1;
              state     <= S_PCI;
            end
          end else begin
            io_port <= host_port;
            state   <= S_IO;
          end
        end
        S_PCI: if (pci_done) begin
          rdata_q <= dn_wr ? 32'h0 : (pci_mabort ? 32'hFFFF_FFFF : pci_rdata);
          state   <= S_ACK;
        end
        S_LOC: if (loc_done) begin
          rdata_q <= dn_wr ? 32'h0 : loc_rdata;
          state   <= S_ACK;
        end
        S_IO: if (io_done) begin
          rdata_q <= dn_wr ? 32'h0 : io_rdata;
          state   <= S_ACK;
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  assert_one_target_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({pci_req, loc_req, io_req}));

  assert_ack_single_R10: assert property (@(posedge clk) disable iff (!rst_n)
    host_ack |=> !host_ack);

  assert_pci_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    pci_req && !pci_done |=> pci_req && $stable(pci_addr) && $stable(pci_type1));

  assert_idsel_onehot_R5: assert property (@(posedge clk) disable iff (!rst_n)
    pci_req && !pci_type1 |-> $onehot0(pci_addr[31:12]) && !pci_addr[11] && pci_addr[1:0] == 2'b00);

  assert_type1_frame_R8: assert property (@(posedge clk) disable iff (!rst_n)
    pci_req && pci_type1 |-> pci_addr[31:24] == 8'h00 && pci_addr[1:0] == 2'b01);

  assert_reserved_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(host_ack) && $past(host_port == ADDR_PORT && host_be == 4'hF && !host_wr)
      |-> host_rdata[30:24] == 7'h0 && host_rdata[1:0] == 2'b00);

endmodule

// File: tb/cfg_xlate_tb.sv
module cfg_xlate_tb;
  localparam int PERIOD = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #(PERIOD/2) clk = ~clk;

  logic        host_req = 0, host_wr = 0;
  logic [13:0] host_port = '0;
  logic [3:0]  host_be = '0;
  logic [31:0] host_wdata = '0;
  logic        host_ack;
  logic [31:0] host_rdata;
  logic        dn_wr;
  logic [3:0]  dn_be;
  logic [31:0] dn_wdata;
  logic        pci_req, pci_type1;
  logic [31:0] pci_addr;
  logic        pci_done = 0, pci_mabort = 0;
  logic [31:0] pci_rdata = '0;
  logic        loc_req;
  logic [8:0]  loc_index;
  logic        loc_done = 0;
  logic [31:0] loc_rdata = '0;
  logic        io_req;
  logic [13:0] io_port;
  logic        io_done = 0;
  logic [31:0] io_rdata = '0;

  cfg_xlate u_dut (.*);

  int n_cmp = 0, n_bad = 0;
  bit finished = 0;
  logic [2:0] exp_tgt = 3'b000;
  logic       exp_ack = 1'b0;
  logic [31:0] m_cfg = '0;

  task automatic chk(input string rq, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", rq, act, exp);
    end
  endtask

  always @(posedge clk) begin
    #(PERIOD/4);
    if (rst_n) begin
      chk("R10 targets", {29'b0, pci_req, loc_req, io_req}, {29'b0, exp_tgt});
      chk("R10 ack", {31'b0, host_ack}, {31'b0, exp_ack});
    end
  end

  // tgt: 4=pci 2=loc 1=io 0=address register
  task automatic access(input logic [13:0] port, input bit wr, input logic [3:0] be,
                        input logic [31:0] wd, input int lat, input logic [31:0] resp,
                        input string rq);
    int bus, dev;
    logic [2:0] tgt;
    logic [31:0] exp_ad, exp_rd;
    bit t1, ma;
    bus = int'(m_cfg[23:16]);
    dev = int'(m_cfg[15:11]);
    t1  = bus != 0;
    ma  = 0;
    if (port == 14'h33E && be == 4'hF) tgt = 3'b000;
    else if (port == 14'h33F && m_cfg[31]) tgt = (bus == 0 && dev == 0) ? 3'b010 : 3'b100;
    else tgt = 3'b001;
    if (t1) exp_ad = (m_cfg & 32'h00FF_FFFC) | 32'h1;
    else begin
      exp_ad = m_cfg & 32'h0000_07FC;
      if (dev >= 1 && dev <= 20) exp_ad = exp_ad | (32'h1 << (11 + dev));
      else ma = 1;
    end
    exp_rd = wr ? 32'h0 : (tgt == 3'b000 ? m_cfg : ((tgt == 3'b100 && ma) ? 32'hFFFF_FFFF : resp));
    @(negedge clk);
    host_req = 1; host_wr = wr; host_port = port; host_be = be; host_wdata = wd;
    if (tgt == 3'b000) begin
      exp_ack = 1;
      if (wr) m_cfg = wd & 32'h80FF_FFFC;
      @(negedge clk);
      chk({rq, " rdata"}, host_rdata, exp_rd);
    end else begin
      exp_tgt = tgt;
      @(negedge clk);
      chk("R9 dir", {31'b0, dn_wr}, {31'b0, wr});
      chk("R9 be", {28'b0, dn_be}, {28'b0, be});
      chk("R9 wdata", dn_wdata, wd);
      if (tgt == 3'b100) begin
        chk({rq, " pci_addr"}, pci_addr, exp_ad);
        chk({rq, " pci_type1"}, {31'b0, pci_type1}, {31'b0, t1});
      end else if (tgt == 3'b010) chk({rq, " loc_index"}, {23'b0, loc_index}, {23'b0, m_cfg[10:2]});
      else chk({rq, " io_port"}, {18'b0, io_port}, {18'b0, port});
      repeat (lat - 1) @(negedge clk);
      case (tgt)
        3'b100: begin pci_done = 1; pci_mabort = ma; pci_rdata = resp; end
        3'b010: begin loc_done = 1; loc_rdata = resp; end
        default: begin io_done = 1; io_rdata = resp; end
      endcase
      exp_tgt = 0; exp_ack = 1;
      @(negedge clk);
      pci_done = 0; pci_mabort = 0; loc_done = 0; io_done = 0;
      chk({rq, " rdata"}, host_rdata, exp_rd);
    end
    host_req = 0; exp_ack = 0;
  endtask

  initial begin
    #(PERIOD * 200000);
    if (!finished) begin
      n_bad++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 host_ack", {31'b0, host_ack}, 32'h0);
    chk("R1 requests", {29'b0, pci_req, loc_req, io_req}, 32'h0);
    rst_n = 1;
    access(14'h33E, 0, 4'hF, 0, 1, 0, "R1 reset address");
    access(14'h33F, 0, 4'hF, 0, 2, 32'h1234_5678, "R4 disabled window");
    access(14'h0020, 1, 4'h3, 32'hCAFE_0001, 1, 0, "R4 other port");
    access(14'h33E, 1, 4'hF, 32'hFF12_3457, 1, 0, "R2 load");
    access(14'h33E, 0, 4'hF, 0, 1, 0, "R2 readback");
    access(14'h33E, 1, 4'h3, 32'h0000_0000, 2, 0, "R3 partial write");
    access(14'h33E, 0, 4'hF, 0, 1, 0, "R3 unchanged");
    for (int d = 0; d < 32; d++) begin
      access(14'h33E, 1, 4'hF, 32'h8000_0000 | (d << 11) | (d[2:0] << 8) | (d << 2), 1, 0, "R2 set");
      access(14'h33F, 0, 4'hF, 0, 1 + d % 3, 32'hA5A5_0000 + d,
             d == 0 ? "R7 local" : (d <= 20 ? "R5 type0" : "R6 abort read"));
      access(14'h33F, 1, 4'h5 + d[3:0], 32'h5A00_0000 + d, 2,
             0, d == 0 ? "R7 local wr" : (d <= 20 ? "R5 type0 wr" : "R6 abort write"));
    end
    access(14'h33E, 1, 4'hF, 32'h8005_0004, 1, 0, "R2 set");
    access(14'h33F, 0, 4'hF, 0, 3, 32'h0BAD_F00D, "R8 type1 bus5 dev0");
    access(14'h33E, 1, 4'hF, 32'hFFFF_FFFF, 1, 0, "R2 set all");
    access(14'h33F, 1, 4'h8, 32'h1357_9BDF, 1, 0, "R8 type1 bus255");
    access(14'h33E, 0, 4'hF, 0, 1, 0, "R2 readback all");
    access(14'h33E, 1, 4'hF, 32'h0000_0800, 1, 0, "R2 disable");
    access(14'h33F, 0, 4'hF, 0, 2, 32'h7777_0000, "R4 disabled again");
    repeat (3) @(negedge clk);
    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule